// File: doc/BRIEF.md
# Lock-Aware Fixed-Priority Bus Arbiter

The block arbitrates a shared bus among a parameterised set of masters. Each master has a request line and receives a one-hot grant line. Once per bus cycle the arbiter registers the requests, a shared lock flag and a transfer-wait flag. On the following edge it recomputes the grant from those registered values.

When the bus is not locked, the grant goes to the requesting master with the lowest index. When the bus is locked, the grant stays with the master that currently owns the bus. When nobody requests, a designated default master is granted.

Granting a master and handing it the bus are kept apart. The arbiter tracks the actual owner, and ownership moves to the granted master only on an edge where the registered wait flag is low. While a transfer is stalled, the pending grant may move to a higher-priority requester. A one-cycle handover pulse marks each change of owner. The lock flag is disregarded during that pulse cycle, so a newly arrived owner cannot inherit a stale lock.

Top module: `lock_arb`

## Requirements
- R1: Exactly one bit of `gnt_o` is high in every cycle after reset.
- R2: `req_i`, `lock_i` and `wait_i` are captured on a rising edge, and `gnt_o` reflects them after the next rising edge, two edges after they were driven.
- R3: When the registered lock is low (or ignored), the grant goes to the requesting master with the lowest index.
- R4: When the registered lock is high and `handover_o` is low, the grant is set to the current owner, whatever the requests are.
- R5: `owner_o` takes the granted index on a rising edge only if the registered wait flag is low and the grant differs from the owner; otherwise it holds.
- R6: `handover_o` is high for exactly the one cycle following each change of `owner_o`, and low otherwise.
- R7: In a cycle where `handover_o` is high, the lock flag has no effect on the next grant; the grant follows R3 and R8.
- R8: With no registered request and the lock not in effect, master `DEFAULT_IDX` (default 3) is granted.
- R9: While the registered wait flag stays high, the grant may move to a newly arriving higher-priority requester, and `owner_o` does not change.
- R10: During and right after reset, `gnt_o` has only bit `DEFAULT_IDX` set, `owner_o` equals `DEFAULT_IDX`, and `handover_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock, one bus cycle per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Bus request per master, bit i for master i |
| lock_i | input | 1 | Shared lock flag from the current owner |
| wait_i | input | 1 | High while the current transfer is stalled |
| gnt_o | output | N_MASTERS | One-hot grant, bit i for master i |
| owner_o | output | IDX_W | Index of the master owning the bus |
| handover_o | output | 1 | One-cycle pulse after each ownership change |

## Verification
Two functions can fall in the same cycle. Ownership can pass to a new master in the very cycle in which that master's requests and an asserted lock flag are evaluated.

The bench provokes this by raising the lock together with a higher-priority request so that both reach the grant logic during the handover pulse. It expects the grant to move to the new requester rather than be pinned by the lock. It also raises a higher-priority request while a transfer is stalled and then releases the stall. There it expects the grant to move at once, and the owner to follow only after the release. A behavioural model in the bench judges every other cycle of a long random run.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lock_arb_sampler.sv
module lock_arb_sampler #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 lock_i,
  input  logic                 wait_i,
  output logic [N_MASTERS-1:0] req_q_o,
  output logic                 lock_q_o,
  output logic                 wait_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q_o  <= '0;
      lock_q_o <= 1'b0;
      wait_q_o <= 1'b0;
    end else begin
      req_q_o  <= req_i;
      lock_q_o <= lock_i;
      wait_q_o <= wait_i;
    end
  end
endmodule

// File: rtl/lock_arb_prio.sv
module lock_arb_prio #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_MASTERS-1:0] req_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     pick_o
);
  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    pick_o = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (req_i[i]) pick_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/lock_arb_owner.sv
module lock_arb_owner #(
  parameter int N_MASTERS   = 4,
  parameter int IDX_W       = 2,
  parameter int DEFAULT_IDX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] gnt_idx_i,
  input  logic             wait_q_i,
  output logic [IDX_W-1:0] owner_o,
  output logic             handover_o
);
  localparam logic [IDX_W-1:0] DEF = IDX_W'(DEFAULT_IDX);

  logic take;
  assign take = !wait_q_i && (gnt_idx_i != owner_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_o    <= DEF;
      handover_o <= 1'b0;
    end else begin
      if (take) owner_o <= gnt_idx_i;
      handover_o <= take;
    end
  end

  // R5 / R9: a stalled transfer keeps its owner
  a_r5_hold_when_waited: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q_i |=> $stable(owner_o));

  // R6: pulse only after a real change of owner
  a_r6_pulse_marks_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o != $past(owner_o)) |-> handover_o);
endmodule

// File: rtl/lock_arb.sv
module lock_arb #(
  parameter int N_MASTERS   = 4,
  parameter int DEFAULT_IDX = 3,
  parameter int IDX_W       = lock_arb_pkg::idx_width(N_MASTERS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 lock_i,
  input  logic                 wait_i,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic [IDX_W-1:0]     owner_o,
  output logic                 handover_o
);
  localparam logic [IDX_W-1:0] DEF = IDX_W'(DEFAULT_IDX);

  logic [N_MASTERS-1:0] req_q;
  logic                 lock_q, wait_q;
  logic                 any_req;
  logic [IDX_W-1:0]     pick_idx, gnt_idx_d, gnt_idx_q;
  logic                 lock_eff;

  lock_arb_sampler #(.N_MASTERS(N_MASTERS)) u_smp (
    .clk_i, .rst_ni, .req_i, .lock_i, .wait_i,
    .req_q_o(req_q), .lock_q_o(lock_q), .wait_q_o(wait_q)
  );

  lock_arb_prio #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_prio (
    .req_i(req_q), .any_o(any_req), .pick_o(pick_idx)
  );

  // lock disregarded in the handover cycle
  assign lock_eff = lock_q && !handover_o;

  always_comb begin
    if (lock_eff)     gnt_idx_d = owner_o;
    else if (any_req) gnt_idx_d = pick_idx;
    else              gnt_idx_d = DEF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_idx_q <= DEF;
    else         gnt_idx_q <= gnt_idx_d;
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
    assign gnt_o[g] = (gnt_idx_q == IDX_W'(g));
  end

  lock_arb_owner #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W), .DEFAULT_IDX(DEFAULT_IDX)) u_own (
    .clk_i, .rst_ni, .gnt_idx_i(gnt_idx_q), .wait_q_i(wait_q),
    .owner_o, .handover_o
  );

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) == 1);

  a_r4_lock_keeps_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !handover_o) |=> (gnt_o[$past(owner_o)]));

  a_r8_idle_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_eff && req_q == '0) |=> gnt_o[DEFAULT_IDX]);

  a_r3_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_eff && req_q[0]) |=> gnt_o[0]);
endmodule

// File: tb/lock_arb_tb.sv
module lock_arb_tb;
  localparam int N   = 4;
  localparam int DEF = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         lock = 1'b0, wt = 1'b0;
  logic [N-1:0] gnt;
  logic [1:0]   owner;
  logic         hand;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lock_arb #(.N_MASTERS(N), .DEFAULT_IDX(DEF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lock_i(lock), .wait_i(wt),
    .gnt_o(gnt), .owner_o(owner), .handover_o(hand)
  );

  // behavioural reference
  int m_rq = 0, m_g = DEF, m_own = DEF;
  bit m_lk = 0, m_wt = 0, m_hd = 0;

  function automatic int lowest(input int v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq = 0; m_lk = 0; m_wt = 0; m_g = DEF; m_own = DEF; m_hd = 0;
    end else begin
      int ng, nown;
      bit nhd;
      if (m_lk && !m_hd)  ng = m_own;
      else if (m_rq != 0) ng = lowest(m_rq);
      else                ng = DEF;
      nhd  = !m_wt && (m_g != m_own);
      nown = nhd ? m_g : m_own;
      m_rq = int'(req); m_lk = lock; m_wt = wt;
      m_g = ng; m_own = nown; m_hd = nhd;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp();
    chk("R1 onehot", $countones(gnt), 1);
    chk("R3 grant vs model", int'(gnt), 1 << m_g);
    chk("R5 owner vs model", int'(owner), m_own);
    chk("R6 handover vs model", int'(hand), int'(m_hd));
  endtask

  task automatic tick();
    @(negedge clk);
    cmp();
  endtask

  task automatic idle(input int n);
    req = '0; lock = 0; wt = 0;
    repeat (n) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset grant", int'(gnt), 1 << DEF);
    chk("R10 reset owner", int'(owner), DEF);
    chk("R10 reset handover", int'(hand), 0);
    rst_n = 1'b1;
    tick();
    chk("R8 idle default", int'(gnt), 1 << DEF);

    // R2/R3: latency and lowest index
    req = 4'b1010;
    tick();
    chk("R2 no change after one edge", int'(gnt), 1 << DEF);
    tick();
    chk("R3 lowest requester", int'(gnt), 4'b0010);
    idle(6);

    // R7: lock raised together with handover
    req = 4'b0010;
    tick(); tick();
    chk("R2 grant to master 1", int'(gnt), 4'b0010);
    req = 4'b0001; lock = 1;
    tick();
    chk("R5 owner now 1", int'(owner), 1);
    chk("R6 pulse", int'(hand), 1);
    tick();
    chk("R7 lock ignored in handover cycle", int'(gnt), 4'b0001);
    repeat (4) tick();
    chk("R5 owner now 0", int'(owner), 0);
    req = 4'b0010;
    repeat (4) tick();
    chk("R4 lock holds owner 0", int'(gnt), 4'b0001);
    chk("R6 no pulse when stable", int'(hand), 0);
    idle(6);
    chk("R8 back to default", int'(gnt), 1 << DEF);

    // R9: preempt pending grant while waited
    wt = 1; req = 4'b0100;
    tick(); tick(); tick();
    chk("R9 pending grant 2", int'(gnt), 4'b0100);
    chk("R9 owner held", int'(owner), DEF);
    req = 4'b0110;
    tick(); tick();
    chk("R9 grant moved to 1", int'(gnt), 4'b0010);
    chk("R9 owner still held", int'(owner), DEF);
    wt = 0;
    tick(); tick();
    chk("R5 owner after release", int'(owner), 1);
    chk("R6 pulse after release", int'(hand), 1);
    idle(4);

    // random run judged by the model
    for (int k = 0; k < 3000; k++) begin
      req  = N'($urandom);
      lock = ($urandom % 4) == 0;
      wt   = ($urandom % 3) == 0;
      tick();
    end
    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule